// File: doc/BRIEF.md
# Fault Event Queue Producer

This block turns fault reports from an address translation unit into fixed 32-byte records and writes them into a circular buffer in system memory. Software reads the records and owns the read side. The block is the producer. It keeps the write index, and software tells it how far reading has progressed by loading a new consumer index. A system with several security states uses one instance of this block per state.

Each accepted event is latched and emitted as four 64-bit write beats to the slot that the producer index selects. Each beat waits for its acknowledge. The producer index moves on only after the fourth beat is acknowledged. If that commit takes the queue from empty to holding one record, a one-cycle interrupt pulse follows. If an event arrives while every slot holds an unread record, the event is discarded and a sticky flag flips its value. Software can then detect lost events by comparing the flag against the last value it saw.

Top module: `evtq_producer`

## Requirements
- R1: After synchronous reset, `prod_idx` is 0, `irq` is 0, `ovf_flag` is 0, `wr_req` is 0 and `evt_ready` is 1.
- R2: The record layout is as follows. Beat 0 carries `{sid, 24'b0, type}`, so the type code sits in bits [7:0] and the stream number sits in bits [63:32]. Beat 1 carries `{32'b0, info}`. Beat 2 carries the faulting address. Beat 3 is all zeros.
- R3: Beat b of a record goes to `cfg_base + slot*32 + b*8`, where slot is `prod_idx` modulo DEPTH. The four beats go out in the order 0, 1, 2, 3.
- R4: While `wr_req` is high and `wr_ack` is low, `wr_req`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R5: `evt_ready` is low from the cycle after an event is accepted until the record commits. `prod_idx` increments by one only in the cycle after the fourth beat is acknowledged. Its top bit is a wrap bit, so the count runs modulo 2*DEPTH.
- R6: `irq` is high for exactly one cycle, in the cycle after a commit, and only if the producer and consumer indices were equal (wrap bit included) just before that commit.
- R7: The queue is full when the two indices agree in their low bits and differ in the wrap bit. An event accepted while the queue is full is dropped. A dropped event produces no beats, leaves `prod_idx` unchanged and inverts `ovf_flag` in the next cycle. At all other times `ovf_flag` holds its value.
- R8: `cons_wr_en` loads `cons_wr_idx` as the new consumer index. The full and empty decisions made in a cycle use the consumer index from before any load in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | AW | Byte address of slot 0 of the buffer |
| evt_valid | input | 1 | A fault event is offered |
| evt_ready | output | 1 | The block can take an event this cycle |
| evt_type | input | 8 | Fault type code |
| evt_sid | input | SIDW | Stream number of the faulting transaction |
| evt_info | input | 32 | Extra syndrome word |
| evt_addr | input | VAW | Faulting input address |
| cons_wr_en | input | 1 | Load a new consumer index |
| cons_wr_idx | input | log2(DEPTH)+1 | Consumer index value, including the wrap bit |
| prod_idx | output | log2(DEPTH)+1 | Producer index, including the wrap bit |
| wr_req | output | 1 | Memory write beat is valid |
| wr_addr | output | AW | Byte address of the beat |
| wr_data | output | 64 | Beat data |
| wr_ack | input | 1 | Memory accepts the current beat |
| irq | output | 1 | Empty-to-non-empty pulse |
| ovf_flag | output | 1 | Toggles on each dropped event |

## Verification
The two functions that can meet in one cycle are event acceptance and a consumer index load. The case that matters is an event arriving at a full queue in the same cycle that software frees slots. The bench fills a four-slot queue and offers one event alone. It then offers a second event together with a consumer load. Both events must be dropped, `ovf_flag` must toggle twice and no beats may appear. The following event must then land in the freed slot without an interrupt, because the queue was not empty.

// File: rtl/evtq_pkg.sv
package evtq_pkg;
  localparam int BEAT_W    = 64;
  localparam int BEATS     = 4;
  localparam int BEAT_IW   = $clog2(BEATS);
  localparam int REC_BYTES = 32;
  localparam int SLOT_SH   = $clog2(REC_BYTES);
  localparam int BYTE_SH   = $clog2(BEAT_W / 8);

  // Fault type codes the translation logic is expected to present
  localparam logic [7:0] EVC_UNSUPPORTED = 8'h01;
  localparam logic [7:0] EVC_BAD_CONFIG  = 8'h02;
  localparam logic [7:0] EVC_XLATE       = 8'h10;
  localparam logic [7:0] EVC_ADDR_SIZE   = 8'h11;
  localparam logic [7:0] EVC_ACCESS_FLAG = 8'h12;
  localparam logic [7:0] EVC_PERMISSION  = 8'h13;

  typedef struct packed {
    logic [7:0]  code;
    logic [31:0] sid;
    logic [31:0] info;
    logic [63:0] addr;
  } evt_rec_t;

  typedef enum logic {ST_IDLE, ST_WRITE} prod_state_t;
endpackage

// File: rtl/evtq_ptrs.sv
module evtq_ptrs #(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic          cons_wr_en,
  input  logic [IW:0]   cons_wr_idx,
  output logic [IW:0]   prod_q,
  output logic [IW:0]   cons_q,
  output logic          full,
  output logic          empty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      cons_q <= '0;
    end else begin
      if (commit)     prod_q <= prod_q + (IW+1)'(1);
      if (cons_wr_en) cons_q <= cons_wr_idx;
    end
  end

  always_comb begin
    empty = (prod_q == cons_q);
    full  = (prod_q[IW-1:0] == cons_q[IW-1:0]) && (prod_q[IW] != cons_q[IW]);
  end
endmodule

// File: rtl/evtq_fmt.sv
module evtq_fmt
  import evtq_pkg::*;
(
  input  evt_rec_t               rec,
  input  logic [BEAT_IW-1:0]     beat,
  output logic [BEAT_W-1:0]      data
);
  always_comb begin
    case (beat)
      2'd0:    data = {rec.sid, 24'd0, rec.code};
      2'd1:    data = {32'd0, rec.info};
      2'd2:    data = rec.addr;
      default: data = '0;
    endcase
  end
endmodule

// File: rtl/evtq_producer.sv
module evtq_producer
  import evtq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 48,
  parameter int SIDW  = 32,
  parameter int VAW   = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     cfg_base,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [7:0]        evt_type,
  input  logic [SIDW-1:0]   evt_sid,
  input  logic [31:0]       evt_info,
  input  logic [VAW-1:0]    evt_addr,
  input  logic              cons_wr_en,
  input  logic [IW:0]       cons_wr_idx,
  output logic [IW:0]       prod_idx,
  output logic              wr_req,
  output logic [AW-1:0]     wr_addr,
  output logic [BEAT_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              irq,
  output logic              ovf_flag
);
  localparam int OFF_W = IW + SLOT_SH;

  prod_state_t          state_q;
  evt_rec_t             rec_q;
  logic [BEAT_IW-1:0]   beat_q;
  logic                 irq_q;
  logic                 ovf_q;
  logic [IW:0]          prod_q;
  logic [IW:0]          cons_q;
  logic                 q_full;
  logic                 q_empty;
  logic                 accept;
  logic                 take;
  logic                 drop;
  logic                 last_ack;
  logic [OFF_W-1:0]     offset;

  assign accept   = evt_valid && (state_q == ST_IDLE);
  assign take     = accept && !q_full;
  assign drop     = accept && q_full;
  assign last_ack = (state_q == ST_WRITE) && wr_ack && (beat_q == BEAT_IW'(BEATS - 1));

  evtq_ptrs #(.IW(IW)) u_ptrs (
    .clk         (clk),
    .rst         (rst),
    .commit      (last_ack),
    .cons_wr_en  (cons_wr_en),
    .cons_wr_idx (cons_wr_idx),
    .prod_q      (prod_q),
    .cons_q      (cons_q),
    .full        (q_full),
    .empty       (q_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rec_q   <= '0;
      beat_q  <= '0;
      irq_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (take) begin
        rec_q.code <= evt_type;
        rec_q.sid  <= 32'(evt_sid);
        rec_q.info <= evt_info;
        rec_q.addr <= 64'(evt_addr);
        beat_q     <= '0;
        state_q    <= ST_WRITE;
      end
      if (drop) ovf_q <= ~ovf_q;
      if (state_q == ST_WRITE && wr_ack) begin
        if (last_ack) begin
          state_q <= ST_IDLE;
          irq_q   <= q_empty;
        end else begin
          beat_q <= beat_q + BEAT_IW'(1);
        end
      end
    end
  end

  evtq_fmt u_fmt (
    .rec  (rec_q),
    .beat (beat_q),
    .data (wr_data)
  );

  assign offset    = {prod_q[IW-1:0], beat_q, BYTE_SH'(0)};
  assign wr_addr   = cfg_base + AW'(offset);
  assign wr_req    = (state_q == ST_WRITE);
  assign evt_ready = (state_q == ST_IDLE);
  assign prod_idx  = prod_q;
  assign irq       = irq_q;
  assign ovf_flag  = ovf_q;
endmodule

// File: rtl/evtq_producer_chk.sv
module evtq_producer_chk #(
  parameter int DEPTH = 64,
  parameter int AW    = 48,
  localparam int IW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          evt_valid,
  input logic          evt_ready,
  input logic          wr_req,
  input logic          wr_ack,
  input logic [AW-1:0] wr_addr,
  input logic [63:0]   wr_data,
  input logic [IW:0]   prod_idx,
  input logic [IW:0]   cons_q,
  input logic          irq,
  input logic          ovf_flag
);
  logic          full_seen;
  logic [IW:0]   occ;
  assign full_seen = (prod_idx[IW-1:0] == cons_q[IW-1:0]) && (prod_idx[IW] != cons_q[IW]);
  assign occ       = prod_idx - cons_q;

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data)); // R4
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    evt_ready |-> !wr_req); // R5
  AST_PROD_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    !$stable(prod_idx) |-> $past(wr_req && wr_ack)); // R5
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R6
  AST_DROP_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    evt_valid && evt_ready && full_seen |=> ovf_flag != $past(ovf_flag)); // R7
  AST_OVF_STEADY: assert property (@(posedge clk) disable iff (rst)
    !(evt_valid && evt_ready && full_seen) |=> $stable(ovf_flag)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    occ <= (IW+1)'(DEPTH)); // R7
endmodule

bind evtq_producer evtq_producer_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_valid (evt_valid),
  .evt_ready (evt_ready),
  .wr_req    (wr_req),
  .wr_ack    (wr_ack),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .prod_idx  (prod_idx),
  .cons_q    (cons_q),
  .irq       (irq),
  .ovf_flag  (ovf_flag)
);

// File: tb/evtq_producer_bench.sv
module evtq_producer_bench;
  localparam int DEPTH = 4;
  localparam int AW    = 48;
  localparam int IW    = $clog2(DEPTH);
  localparam logic [AW-1:0] BASE = 48'h0000_8000_1000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cfg_base = BASE;
  logic          evt_valid = 1'b0;
  logic          evt_ready;
  logic [7:0]    evt_type = '0;
  logic [31:0]   evt_sid = '0;
  logic [31:0]   evt_info = '0;
  logic [63:0]   evt_addr = '0;
  logic          cons_wr_en = 1'b0;
  logic [IW:0]   cons_wr_idx = '0;
  logic [IW:0]   prod_idx;
  logic          wr_req;
  logic [AW-1:0] wr_addr;
  logic [63:0]   wr_data;
  logic          wr_ack = 1'b0;
  logic          irq;
  logic          ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] exp_addr[$];
  logic [63:0]   exp_data[$];
  logic [IW:0]   m_prod = '0;
  logic [IW:0]   m_cons = '0;
  logic          m_ovf = 1'b0;
  bit            stall_mode = 1'b0;
  int            stall_ctr = 0;
  bit            held = 1'b0;
  logic [AW-1:0] held_addr;
  logic [63:0]   held_data;

  always #5 clk = ~clk;

  evtq_producer #(.DEPTH(DEPTH), .AW(AW), .SIDW(32), .VAW(64)) u_evtq_producer (
    .clk(clk), .rst(rst), .cfg_base(cfg_base),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_type(evt_type),
    .evt_sid(evt_sid), .evt_info(evt_info), .evt_addr(evt_addr),
    .cons_wr_en(cons_wr_en), .cons_wr_idx(cons_wr_idx), .prod_idx(prod_idx),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .irq(irq), .ovf_flag(ovf_flag)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: memory model that acknowledges beats and pops the scoreboard
  always @(negedge clk) begin
    wr_ack = 1'b0;
    if (!rst && wr_req) begin
      if (held) begin
        check("R4 held addr", 64'(wr_addr), 64'(held_addr));
        check("R4 held data", wr_data, held_data);
      end
      stall_ctr++;
      if (!stall_mode || stall_ctr[0]) begin
        held = 1'b0;
        if (exp_addr.size() == 0) begin
          check("R7 unexpected beat", 64'(wr_addr), 64'hffff_ffff_ffff_ffff);
        end else begin
          check("R3 beat address", 64'(wr_addr), 64'(exp_addr.pop_front()));
          check("R2 beat data", wr_data, exp_data.pop_front());
        end
        wr_ack = 1'b1;
      end else begin
        held = 1'b1;
        held_addr = wr_addr;
        held_data = wr_data;
      end
    end else begin
      held = 1'b0;
    end
  end

  // Driver: offers one event, optionally with a simultaneous consumer load
  task automatic send(logic [7:0] ty, logic [31:0] sid, logic [31:0] info,
                      logic [63:0] addr, bit with_cons, logic [IW:0] cval);
    bit exp_full;
    bit exp_empty;
    @(negedge clk);
    while (!evt_ready) @(negedge clk);
    exp_full  = (m_prod[IW-1:0] == m_cons[IW-1:0]) && (m_prod[IW] != m_cons[IW]);
    exp_empty = (m_prod == m_cons);
    evt_type = ty; evt_sid = sid; evt_info = info; evt_addr = addr;
    evt_valid = 1'b1;
    if (with_cons) begin
      cons_wr_en = 1'b1;
      cons_wr_idx = cval;
    end
    if (!exp_full) begin
      for (int b = 0; b < 4; b++) begin
        exp_addr.push_back(BASE + AW'({m_prod[IW-1:0], 5'd0}) + AW'(b * 8));
      end
      exp_data.push_back({sid, 24'd0, ty});
      exp_data.push_back({32'd0, info});
      exp_data.push_back(addr);
      exp_data.push_back(64'd0);
    end
    @(negedge clk);
    evt_valid = 1'b0;
    cons_wr_en = 1'b0;
    if (with_cons) m_cons = cval;
    if (exp_full) begin
      m_ovf = ~m_ovf;
      check("R7 ovf toggle on drop", 64'(ovf_flag), 64'(m_ovf));
      check("R7 prod unchanged on drop", 64'(prod_idx), 64'(m_prod));
      check("R7 no irq on drop", 64'(irq), 64'd0);
    end else begin
      check("R5 busy while writing", 64'(evt_ready), 64'd0);
      while (!evt_ready) @(negedge clk);
      m_prod = m_prod + 1'b1;
      check("R5 prod after commit", 64'(prod_idx), 64'(m_prod));
      check("R6 irq on commit", 64'(irq), 64'(exp_empty));
      check("R3 all beats seen", 64'(exp_addr.size()), 64'd0);
      check("R7 ovf steady", 64'(ovf_flag), 64'(m_ovf));
      @(negedge clk);
      check("R6 irq single cycle", 64'(irq), 64'd0);
    end
  endtask

  task automatic consume(logic [IW:0] v);
    @(negedge clk);
    cons_wr_en = 1'b1;
    cons_wr_idx = v;
    @(negedge clk);
    cons_wr_en = 1'b0;
    m_cons = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 prod_idx", 64'(prod_idx), 64'd0);
    check("R1 irq", 64'(irq), 64'd0);
    check("R1 ovf_flag", 64'(ovf_flag), 64'd0);
    check("R1 wr_req", 64'(wr_req), 64'd0);
    check("R1 evt_ready", 64'(evt_ready), 64'd1);

    send(8'h10, 32'h0000_0011, 32'hA5A5_0001, 64'h1234_5678_9ABC_DEF0, 1'b0, '0); // R6 empty -> irq
    send(8'h13, 32'hDEAD_BEEF, 32'h0000_0002, 64'hFFFF_0000_0000_1000, 1'b0, '0); // no irq
    consume(3'd2);                                                              // R8
    send(8'h01, 32'h0000_0007, 32'h0000_0003, 64'h0000_0000_0000_0040, 1'b0, '0); // empty again
    stall_mode = 1'b1;                                                          // R4
    send(8'h11, 32'h0000_0100, 32'h0000_0004, 64'h0000_00AB_0000_0000, 1'b0, '0); // slot 3
    send(8'h12, 32'h0000_0200, 32'h0000_0005, 64'h0000_0000_CAFE_0000, 1'b0, '0); // slot 0, wrap
    send(8'h02, 32'h0000_0300, 32'h0000_0006, 64'h0000_0000_0000_0008, 1'b0, '0); // now full
    send(8'h10, 32'h0000_0400, 32'h0000_0007, 64'h1, 1'b0, '0);                   // R7 dropped
    send(8'h13, 32'h0000_0500, 32'h0000_0008, 64'h2, 1'b1, 3'd4);                 // R8 drop with free
    send(8'h11, 32'h0000_0600, 32'h0000_0009, 64'h3, 1'b0, '0);                   // into freed slot
    stall_mode = 1'b0;
    consume(3'd7);
    send(8'h12, 32'h0000_0700, 32'h0000_000A, 64'h4, 1'b0, '0);                   // irq, prod wraps
    check("R5 prod modulo 2*DEPTH", 64'(prod_idx), 64'd0);
    repeat (4) @(negedge clk);
    check("R7 no stray beats", 64'(exp_addr.size()), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule